// File: doc/BRIEF.md
# Majority-Vote Sampled Register Reader

This block reads a register that sometimes returns a corrupted value on a single access. When a read is requested, the block samples the target register again and again, up to a parameterised limit. It keeps a table of the distinct values it has seen, each with a count of how many times it appeared. It then returns the value that appeared most often. It stops sampling early once one value has been seen in more than half of the sample limit. At that point no other value can overtake it.

A requester raises a one-cycle request with an address while the block is idle. The block drives a read strobe and the captured address toward the register. It takes the returned data one cycle after each strobe. When it finishes, it pulses `done` for one cycle and presents the winning value together with the number of samples it took. Requests that arrive while `busy` is high are ignored.

Top module: `mvr_reader`

## Requirements
- R1: After a request is accepted, `smp_rd` is high for one cycle in every two, with `smp_addr` equal to the address captured at acceptance. The value on `smp_data` in the cycle after each strobe is that sample.
- R2: A read takes at most N samples (default 100). `nsamp` reports the number of samples actually taken, from 1 to N.
- R3: `result` is the value with the highest occurrence count among the samples taken in that read.
- R4: Sampling ends on the sample that raises some value's count to N/2+1, using integer division (51 for the default). If that never happens, sampling ends after N samples.
- R5: When counts tie, the value that first reached the highest count is kept. A later value replaces it only with a strictly greater count.
- R6: `busy` is high from the cycle after a request is accepted until the cycle in which `done` pulses. A `req_valid` seen while busy has no effect on the address being sampled or on the result.
- R7: `done` is high for exactly one cycle per accepted request. `result` and `nsamp` take their new values in that cycle and hold them until the next `done`.
- R8: The tally table starts empty on every request, so values sampled in one read do not count toward the next.
- R9: After reset, `busy`, `done`, `smp_rd`, `result` and `nsamp` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request, accepted only when not busy |
| req_addr | input | AW | Address of the register to read |
| busy | output | 1 | A read is in progress and new requests are ignored |
| smp_rd | output | 1 | Sample read strobe toward the register |
| smp_addr | output | AW | Address driven with each sample strobe |
| smp_data | input | DW | Sample value, valid in the cycle after `smp_rd` |
| done | output | 1 | One-cycle pulse when the result is ready |
| result | output | DW | Most frequent sampled value |
| nsamp | output | CW | Number of samples taken for `result` |

## Verification
A wrong entry count or a stale entry in the tally table shows up at the ports as a wrong `result`, or as an early exit on the wrong sample. The early exit is visible as `done` arriving at a different cycle than the model predicts, so the error is seen at the end of the affected read. A wrong running maximum has the same effect. It either flips a tie to the later value or moves the exit point, so it is caught on the same read. Control faults in the state sequencing appear within one clock as a mismatch on `busy`, `smp_rd` or `smp_addr`. This is because the reference model predicts every one of those pins on every cycle.

// File: rtl/mvr_pkg.sv
package mvr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } mvr_state_t;
endpackage

// File: rtl/mvr_tally.sv
// Distinct-value tally with running maximum; the table is emptied by clr (R8).
module mvr_tally #(
  parameter int N  = 100,
  parameter int DW = 32,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          upd,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] nxt_best,
  output logic [CW-1:0] nxt_max
);
  logic [DW-1:0] val_q [N];
  logic [CW-1:0] cnt_q [N];
  logic [CW-1:0] fill_q, max_q, hit_cnt, upd_cnt;
  logic [DW-1:0] best_q;
  logic [N-1:0]  match;
  logic          hit;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = (CW'(g) < fill_q) && (val_q[g] == din);
  end

  always_comb begin
    hit     = 1'b0;
    hit_cnt = '0;
    for (int j = 0; j < N; j++) begin
      if (match[j]) begin
        hit     = 1'b1;
        hit_cnt = cnt_q[j];
      end
    end
    upd_cnt = hit ? hit_cnt + 1'b1 : CW'(1);
    // strictly greater replaces: ties keep the earlier leader (R5)
    if (upd_cnt > max_q) begin
      nxt_max  = upd_cnt;
      nxt_best = din;
    end else begin
      nxt_max  = max_q;
      nxt_best = best_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
      max_q  <= '0;
      best_q <= '0;
    end else if (clr) begin
      fill_q <= '0;
      max_q  <= '0;
      best_q <= '0;
    end else if (upd) begin
      max_q  <= nxt_max;
      best_q <= nxt_best;
      if (!hit) fill_q <= fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < N; j++) begin
      if (upd && (hit ? match[j] : (fill_q == CW'(j)))) begin
        val_q[j] <= din;
        cnt_q[j] <= upd_cnt;
      end
    end
  end
endmodule

// File: rtl/mvr_ctrl.sv
// Request acceptance, sample sequencing and early-exit decision.
module mvr_ctrl
  import mvr_pkg::*;
#(
  parameter int N  = 100,
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] nxt_best,
  input  logic [CW-1:0] nxt_max,
  output logic          tally_clr,
  output logic          tally_upd,
  output logic          busy,
  output logic          smp_rd,
  output logic [AW-1:0] smp_addr,
  output logic          done,
  output logic [DW-1:0] result,
  output logic [CW-1:0] nsamp
);
  localparam int HALF = N / 2;

  mvr_state_t    state_q;
  logic [CW-1:0] taken_q, taken_nxt;
  logic          finish;

  assign tally_clr = (state_q == ST_IDLE) && req_valid;
  assign tally_upd = (state_q == ST_WAIT);
  assign busy      = (state_q != ST_IDLE);
  assign smp_rd    = (state_q == ST_ISSUE);
  assign taken_nxt = taken_q + 1'b1;
  assign finish    = (nxt_max > CW'(HALF)) || (taken_nxt == CW'(N));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      taken_q  <= '0;
      smp_addr <= '0;
      done     <= 1'b0;
      result   <= '0;
      nsamp    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          state_q  <= ST_ISSUE;
          smp_addr <= req_addr;
          taken_q  <= '0;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          taken_q <= taken_nxt;
          if (finish) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
            result  <= nxt_best;
            nsamp   <= taken_nxt;
          end else begin
            state_q <= ST_ISSUE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mvr_reader.sv
module mvr_reader #(
  parameter int N  = 100,
  parameter int DW = 32,
  parameter int AW = 8,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          busy,
  output logic          smp_rd,
  output logic [AW-1:0] smp_addr,
  input  logic [DW-1:0] smp_data,
  output logic          done,
  output logic [DW-1:0] result,
  output logic [CW-1:0] nsamp
);
  logic          tally_clr, tally_upd;
  logic [DW-1:0] nxt_best;
  logic [CW-1:0] nxt_max;

  mvr_tally #(.N(N), .DW(DW), .CW(CW)) u_tally (
    .clk(clk), .rst(rst), .clr(tally_clr), .upd(tally_upd),
    .din(smp_data), .nxt_best(nxt_best), .nxt_max(nxt_max)
  );

  mvr_ctrl #(.N(N), .DW(DW), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .nxt_best(nxt_best), .nxt_max(nxt_max),
    .tally_clr(tally_clr), .tally_upd(tally_upd),
    .busy(busy), .smp_rd(smp_rd), .smp_addr(smp_addr),
    .done(done), .result(result), .nsamp(nsamp)
  );
endmodule

// File: rtl/mvr_reader_chk.sv
module mvr_reader_chk #(
  parameter int N  = 100,
  parameter int DW = 32,
  parameter int CW = $clog2(N + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          smp_rd,
  input logic          done,
  input logic [DW-1:0] result,
  input logic [CW-1:0] nsamp
);
  localparam int HALF = N / 2;

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r1_rd_spacing: assert property (@(posedge clk) disable iff (rst)
    smp_rd |=> !smp_rd);
  a_r6_rd_busy: assert property (@(posedge clk) disable iff (rst)
    smp_rd |-> busy);
  a_r6_busy_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
    done |-> (nsamp != '0) && (nsamp <= CW'(N)));
  a_r4_early_exit: assert property (@(posedge clk) disable iff (rst)
    (done && (nsamp < CW'(N))) |-> (nsamp > CW'(HALF)));
  a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(result) && $stable(nsamp)));
endmodule

bind mvr_reader mvr_reader_chk #(.N(N), .DW(DW), .CW(CW)) u_chk (.*);

// File: tb/mvr_reader_tb.sv
module mvr_reader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 100;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          busy, smp_rd, done;
  logic [AW-1:0] smp_addr;
  logic [DW-1:0] smp_data = '0;
  logic [DW-1:0] result;
  logic [CW-1:0] nsamp;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mvr_reader #(.N(N), .DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .smp_rd(smp_rd), .smp_addr(smp_addr), .smp_data(smp_data),
    .done(done), .result(result), .nsamp(nsamp)
  );

  // register model: returns queued samples one cycle after each strobe
  logic [DW-1:0] resp_q[$];
  logic [DW-1:0] model_q[$];
  always @(posedge clk) if (smp_rd && resp_q.size() > 0) smp_data <= resp_q.pop_front();

  // behavioural reference model
  int            ms = 0;
  bit            m_done = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_res = '0, m_best = '0, m_cur = '0;
  int            m_n = 0, m_max = 0, m_taken = 0;
  logic [DW-1:0] tv[$];
  int            tc[$];

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      ms = 0; m_done = 0; m_res = '0; m_n = 0; m_addr = '0;
    end else begin
      m_done = 0;
      case (ms)
        0: if (req_valid) begin
          ms = 1; m_addr = req_addr; tv.delete(); tc.delete();
          m_max = 0; m_best = '0; m_taken = 0;
        end
        1: begin
          ms = 2;
          m_cur = (model_q.size() > 0) ? model_q.pop_front() : '0;
        end
        default: begin
          int c;
          bit found;
          found = 0; c = 1;
          for (int k = 0; k < tv.size(); k++) begin
            if (tv[k] == m_cur) begin tc[k] = tc[k] + 1; c = tc[k]; found = 1; end
          end
          if (!found) begin tv.push_back(m_cur); tc.push_back(1); end
          if (c > m_max) begin m_max = c; m_best = m_cur; end
          m_taken++;
          if (m_max > N / 2 || m_taken == N) begin
            ms = 0; m_done = 1; m_res = m_best; m_n = m_taken;
          end else ms = 1;
        end
      endcase
    end
  end

  task automatic cmp(input string tag, input string what, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0h exp %0h at cycle %0d", tag, what, got, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cmp("R6", "busy", busy, ms != 0);
      cmp("R1", "smp_rd", smp_rd, ms == 1);
      if (smp_rd) cmp("R1", "smp_addr", smp_addr, m_addr);
      cmp("R7", "done", done, m_done);
      cmp("R3", "result", result, m_res);
      cmp("R2", "nsamp", nsamp, m_n);
    end
  end

  task automatic load(input logic [DW-1:0] v);
    resp_q.push_back(v);
    model_q.push_back(v);
  endtask

  task automatic run_read(input string tag, input logic [AW-1:0] a,
                          input logic [DW-1:0] exp_res, input int exp_n, input bit poke);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    if (poke) begin
      // request while busy must be ignored (R6)
      req_valid = 1'b1; req_addr = a ^ 8'hFF;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done && cycles < 150000) @(negedge clk);
    cmp(tag, "final result", result, exp_res);
    cmp(tag, "final nsamp", nsamp, exp_n);
    resp_q.delete(); model_q.delete();
    @(negedge clk);
    cmp("R7", "done low after pulse", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp("R9", "reset busy", busy, 0);
    cmp("R9", "reset done", done, 0);
    cmp("R9", "reset smp_rd", smp_rd, 0);
    cmp("R9", "reset result", result, 0);
    cmp("R9", "reset nsamp", nsamp, 0);
    rst = 1'b0;

    // R4: one value throughout, exit at sample 51
    for (int i = 0; i < N; i++) load(32'hA5A5_0001);
    run_read("R4", 8'h10, 32'hA5A5_0001, 51, 0);

    // R5: alternating values tie at 50/50, first leader kept, all N taken
    for (int i = 0; i < N; i++) load((i % 2 == 0) ? 32'h0000_00AA : 32'h0000_00BB);
    run_read("R5", 8'h21, 32'h0000_00AA, 100, 0);

    // R3: one corrupt sample first, then majority value takes over
    load(32'hDEAD_BEEF);
    for (int i = 1; i < N; i++) load(32'h1234_5678);
    run_read("R3", 8'h32, 32'h1234_5678, 52, 0);

    // R2: all distinct, table fills to N, first value wins
    for (int i = 0; i < N; i++) load(32'(i * 3 + 7));
    run_read("R2", 8'h43, 32'd7, 100, 0);

    // R3: late majority overtakes at sample 81, exits at 91
    for (int i = 0; i < 40; i++) load(32'h0000_0C0C);
    for (int i = 0; i < 60; i++) load(32'h0000_0D0D);
    run_read("R3", 8'h54, 32'h0000_0D0D, 91, 0);

    // R6: request during a read is ignored
    for (int i = 0; i < N; i++) load(32'h7777_0000);
    run_read("R6", 8'h65, 32'h7777_0000, 51, 1);

    // R8: same value read again; table starts empty so 51 samples again
    for (int i = 0; i < N; i++) load(32'h7777_0000);
    run_read("R8", 8'h76, 32'h7777_0000, 51, 0);

    repeat (4) @(negedge clk);
    if (cycles >= 150000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 180000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule